// File: doc/BRIEF.md
# Pipelined Polynomial Sine and Cosine Unit

This block turns a signed angle into its sine and cosine every clock cycle, using truncated power series instead of lookup tables or rotation iterations. The angle is a 16-bit two's-complement code where the code range maps linearly onto the interval from minus pi to just under plus pi. The sine series ends at the 7th power and the cosine series at the 8th power. Both results are 16-bit signed fractions with 15 fraction bits.

Inside, each series term is made from the one before it. A stage multiplies the running term by the angle and by a stored reciprocal 1/k. The result is that stage k holds the k-th power of the angle divided by k factorial. Odd terms go into the sine sum and even terms into the cosine sum, with alternating signs. The cosine sum starts from one. Every term and partial sum is kept at half scale so that the squared angle cannot overflow the internal word. The angle is halved before the chain starts, and the final sums are doubled back when the outputs are rounded. One stage sits between each pair of pipeline registers, and a valid strobe travels beside the data.

The unit accepts a new angle on any cycle. Results come out in input order after a fixed delay, so a caller can feed it a stream of back-to-back samples or isolated requests.

Top module: `taylor_sincos`

## Requirements
- R1: An input code a on `in_angle` stands for the angle a*pi/32768 radians, so -32768 is -pi and +16384 is +pi/2.
- R2: For a valid input, `sin_out` equals round(32768*(t - t^3/6 + t^5/120 - t^7/5040)) for the angle t, within 4 LSB.
- R3: For a valid input, `cos_out` equals round(32768*(1 - t^2/2 + t^4/24 - t^6/720 + t^8/40320)) for the angle t, within 4 LSB.
- R4: Both outputs saturate: a result above 32767 is delivered as 32767 and one below -32768 as -32768.
- R5: `out_valid` is `in_valid` delayed by exactly 9 clock cycles, with one result per accepted input and no gaps when inputs arrive back to back.
- R6: While `out_valid` is low, `sin_out` and `cos_out` keep the last result delivered.
- R7: While `rst_n` is low, `out_valid`, `sin_out` and `cos_out` are 0. Inputs accepted before reset produce no `out_valid` after reset is released.
- R8: An angle code of 0 gives exactly `sin_out` = 0 and `cos_out` = 32767. The codes -32768 and +32767 obey R2 and R3 like any other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_angle` on this cycle |
| in_angle | input | 16 | Signed angle code, full scale = pi |
| out_valid | output | 1 | Marks a fresh result on the outputs |
| sin_out | output | 16 | Sine result, signed, 15 fraction bits |
| cos_out | output | 16 | Cosine result, signed, 15 fraction bits |

## Verification
Every one of the 65536 angle codes is streamed back to back and compared with the polynomial evaluated in real arithmetic. A wrong reciprocal, a swapped term sign or a missing halving would show up as large errors growing toward the ends of the range. The zero angle is checked exactly: its cosine exceeds full scale before rounding, so a design without saturation would wrap to -32768. The extreme codes are checked too, because they carry the largest intermediate terms, and an internal word that is too narrow would overflow only there. A sparse stream with gaps and a reset in the middle of a burst test the valid delay, the holding of outputs, and the flushing of requests still in flight.

// File: rtl/taylor_pkg.sv
package taylor_pkg;

  // How a stage folds its freshly formed term into the running sum
  typedef enum logic {
    TERM_ADD = 1'b0,
    TERM_SUB = 1'b1
  } term_op_e;

  // Powers 0,1 mod 4 add, powers 2,3 mod 4 subtract
  function automatic term_op_e term_op(input int power);
    return ((power % 4) >= 2) ? TERM_SUB : TERM_ADD;
  endfunction

  // Fixed-point pi with 20 fraction bits, used to scale the angle code
  localparam int PI_FRAC = 20;
  localparam logic signed [23:0] PI_Q20 = 24'sd3294199;

endpackage

// File: rtl/taylor_front.sv
// Stage 1: converts the angle code to radians, halves it, seeds both sums.
module taylor_front #(
  parameter int ANG_W  = 16,
  parameter int TERM_W = 20,
  parameter int FRAC   = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [ANG_W-1:0]  in_angle,
  output logic                     v_o,
  output logic signed [TERM_W-1:0] theta_o,
  output logic signed [TERM_W-1:0] term_o,
  output logic signed [TERM_W-1:0] sin_o,
  output logic signed [TERM_W-1:0] cos_o
);
  import taylor_pkg::*;

  localparam int PW  = ANG_W + 24;
  localparam int SH0 = PI_FRAC + (ANG_W - 1) - FRAC;

  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     half0;
  logic signed [TERM_W-1:0] theta_n;
  logic signed [TERM_W-1:0] term_n;
  logic signed [TERM_W-1:0] cos_n;

  always_comb begin
    prod        = in_angle * PI_Q20;
    half0       = '0;
    half0[SH0-1] = 1'b1;
    theta_n     = TERM_W'((prod + half0) >>> SH0);
    // half-scale first term: theta/2, rounded
    term_n      = (theta_n + TERM_W'(1)) >>> 1;
    // half-scale constant one
    cos_n       = '0;
    cos_n[FRAC-1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o     <= 1'b0;
      theta_o <= '0;
      term_o  <= '0;
      sin_o   <= '0;
      cos_o   <= '0;
    end else begin
      v_o <= in_valid;
      if (in_valid) begin
        theta_o <= theta_n;
        term_o  <= term_n;
        sin_o   <= term_n;
        cos_o   <= cos_n;
      end
    end
  end

endmodule

// File: rtl/taylor_term_stage.sv
// Stage for power K: term_K = term_(K-1) * theta * (1/K), then fold into a sum.
module taylor_term_stage #(
  parameter int K       = 2,
  parameter int TERM_W  = 20,
  parameter int FRAC    = 17,
  parameter int RECIP_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic signed [TERM_W-1:0] theta_i,
  input  logic signed [TERM_W-1:0] term_i,
  input  logic signed [TERM_W-1:0] sin_i,
  input  logic signed [TERM_W-1:0] cos_i,
  output logic                     v_o,
  output logic signed [TERM_W-1:0] theta_o,
  output logic signed [TERM_W-1:0] term_o,
  output logic signed [TERM_W-1:0] sin_o,
  output logic signed [TERM_W-1:0] cos_o
);
  import taylor_pkg::*;

  localparam int       P1W       = 2 * TERM_W;
  localparam int       P2W       = P1W + RECIP_W + 1;
  localparam int       SH2       = FRAC + RECIP_W;
  localparam int       RECIP_INT = ((2 ** RECIP_W) + (K / 2)) / K;
  localparam term_op_e OP        = term_op(K);
  localparam bit       TO_SINE   = (K % 2) == 1;

  logic signed [RECIP_W:0]  recip_c;
  logic signed [P1W-1:0]    prod1;
  logic signed [P2W-1:0]    prod2;
  logic signed [P2W-1:0]    half2;
  logic signed [TERM_W-1:0] term_n;
  logic signed [TERM_W-1:0] fold_n;
  logic signed [TERM_W-1:0] sin_n;
  logic signed [TERM_W-1:0] cos_n;

  assign recip_c = RECIP_INT[RECIP_W:0];

  always_comb begin
    prod1 = term_i * theta_i;
    prod2 = prod1 * recip_c;
    half2 = '0;
    half2[SH2-1] = 1'b1;
    term_n = TERM_W'((prod2 + half2) >>> SH2);
    fold_n = TO_SINE ? sin_i : cos_i;
    if (OP == TERM_SUB) fold_n = fold_n - term_n;
    else                fold_n = fold_n + term_n;
    sin_n = TO_SINE ? fold_n : sin_i;
    cos_n = TO_SINE ? cos_i  : fold_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o     <= 1'b0;
      theta_o <= '0;
      term_o  <= '0;
      sin_o   <= '0;
      cos_o   <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        theta_o <= theta_i;
        term_o  <= term_n;
        sin_o   <= sin_n;
        cos_o   <= cos_n;
      end
    end
  end

endmodule

// File: rtl/taylor_back.sv
// Final stage: doubles the half-scale sums, rounds to the output grid, saturates.
module taylor_back #(
  parameter int TERM_W = 20,
  parameter int FRAC   = 17,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic signed [TERM_W-1:0] sin_i,
  input  logic signed [TERM_W-1:0] cos_i,
  output logic                     v_o,
  output logic signed [OUT_W-1:0]  sin_o,
  output logic signed [OUT_W-1:0]  cos_o
);
  localparam int WW      = TERM_W + 1;
  localparam int DSH     = FRAC - OUT_W;
  localparam int MAX_INT = (2 ** (OUT_W - 1)) - 1;
  localparam int MIN_INT = -(2 ** (OUT_W - 1));

  logic signed [OUT_W-1:0] sin_n;
  logic signed [OUT_W-1:0] cos_n;

  function automatic logic signed [OUT_W-1:0] shrink(input logic signed [TERM_W-1:0] acc);
    logic signed [WW-1:0] wide;
    logic signed [WW-1:0] half;
    half = '0;
    half[DSH-1] = 1'b1;
    wide = (WW'(acc) + half) >>> DSH;
    if (wide > WW'(MAX_INT))      return OUT_W'(MAX_INT);
    else if (wide < WW'(MIN_INT)) return OUT_W'(MIN_INT);
    else                          return wide[OUT_W-1:0];
  endfunction

  always_comb begin
    sin_n = shrink(sin_i);
    cos_n = shrink(cos_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        sin_o <= sin_n;
        cos_o <= cos_n;
      end
    end
  end

endmodule

// File: rtl/taylor_sincos.sv
module taylor_sincos #(
  parameter int ANG_W   = 16,
  parameter int OUT_W   = 16,
  parameter int TERM_W  = 20,
  parameter int RECIP_W = 20,
  parameter int MAX_POW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [ANG_W-1:0] in_angle,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out
);
  // two integer bits plus sign hold every half-scale term up to 8th power
  localparam int FRAC    = TERM_W - 3;
  localparam int LATENCY = MAX_POW + 1;

  logic                     v_q     [1:MAX_POW];
  logic signed [TERM_W-1:0] theta_q [1:MAX_POW];
  logic signed [TERM_W-1:0] term_q  [1:MAX_POW];
  logic signed [TERM_W-1:0] sin_q   [1:MAX_POW];
  logic signed [TERM_W-1:0] cos_q   [1:MAX_POW];

  taylor_front #(
    .ANG_W (ANG_W),
    .TERM_W(TERM_W),
    .FRAC  (FRAC)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_angle(in_angle),
    .v_o     (v_q[1]),
    .theta_o (theta_q[1]),
    .term_o  (term_q[1]),
    .sin_o   (sin_q[1]),
    .cos_o   (cos_q[1])
  );

  for (genvar k = 2; k <= MAX_POW; k++) begin : g_stage
    taylor_term_stage #(
      .K      (k),
      .TERM_W (TERM_W),
      .FRAC   (FRAC),
      .RECIP_W(RECIP_W)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_i    (v_q[k-1]),
      .theta_i(theta_q[k-1]),
      .term_i (term_q[k-1]),
      .sin_i  (sin_q[k-1]),
      .cos_i  (cos_q[k-1]),
      .v_o    (v_q[k]),
      .theta_o(theta_q[k]),
      .term_o (term_q[k]),
      .sin_o  (sin_q[k]),
      .cos_o  (cos_q[k])
    );
  end

  taylor_back #(
    .TERM_W(TERM_W),
    .FRAC  (FRAC),
    .OUT_W (OUT_W)
  ) u_back (
    .clk  (clk),
    .rst_n(rst_n),
    .v_i  (v_q[MAX_POW]),
    .sin_i(sin_q[MAX_POW]),
    .cos_i(cos_q[MAX_POW]),
    .v_o  (out_valid),
    .sin_o(sin_out),
    .cos_o(cos_out)
  );

endmodule

// File: rtl/taylor_sincos_chk.sv
module taylor_sincos_chk #(
  parameter int ANG_W = 16,
  parameter int OUT_W = 16,
  parameter int LAT   = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [ANG_W-1:0] in_angle,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] sin_out,
  input logic signed [OUT_W-1:0] cos_out
);
  logic                    vdel [LAT];
  logic signed [ANG_W-1:0] adel [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        vdel[i] <= 1'b0;
        adel[i] <= '0;
      end
    end else begin
      vdel[0] <= in_valid;
      adel[0] <= in_angle;
      for (int i = 1; i < LAT; i++) begin
        vdel[i] <= vdel[i-1];
        adel[i] <= adel[i-1];
      end
    end
  end

  // R7: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_reset_quiet: assert (!out_valid && sin_out == '0 && cos_out == '0);
    end
  end

  // R5: valid travels with the fixed pipeline delay
  a_r5_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vdel[LAT-1]);

  // R6: outputs hold between results
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(sin_out) && $stable(cos_out)));

  // R8: zero angle is exact, with cosine saturated at full scale
  a_r8_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && adel[LAT-1] == '0) |->
      (sin_out == '0 && cos_out == OUT_W'((2 ** (OUT_W - 1)) - 1)));

endmodule

bind taylor_sincos taylor_sincos_chk #(
  .ANG_W(ANG_W),
  .OUT_W(OUT_W),
  .LAT  (MAX_POW + 1)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_angle (in_angle),
  .out_valid(out_valid),
  .sin_out  (sin_out),
  .cos_out  (cos_out)
);

// File: tb/taylor_sincos_test.sv
module taylor_sincos_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  LAT        = 9;
  localparam int  TOL        = 4;
  localparam real PI_R       = 3.14159265358979323846;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_angle;
  logic               out_valid;
  logic signed [15:0] sin_out;
  logic signed [15:0] cos_out;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit                 rv [16];
  logic signed [15:0] ra [16];
  logic signed [15:0] last_s;
  logic signed [15:0] last_c;

  always #(CLK_PERIOD / 2) clk = ~clk;

  taylor_sincos uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_angle (in_angle),
    .out_valid(out_valid),
    .sin_out  (sin_out),
    .cos_out  (cos_out)
  );

  function automatic int to_code(input real x);
    real r;
    r = $floor(x * 32768.0 + 0.5);
    if (r > 32767.0)  r = 32767.0;
    if (r < -32768.0) r = -32768.0;
    return $rtoi(r);
  endfunction

  function automatic int ref_sin(input int a);
    real t;
    t = a * PI_R / 32768.0;
    return to_code(t - t**3 / 6.0 + t**5 / 120.0 - t**7 / 5040.0);
  endfunction

  function automatic int ref_cos(input int a);
    real t;
    t = a * PI_R / 32768.0;
    return to_code(1.0 - t**2 / 2.0 + t**4 / 24.0 - t**6 / 720.0 + t**8 / 40320.0);
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic cmp_tol(input string req, input string what, input int act, input int exp);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > TOL) fail(req, what, act, exp);
  endtask

  task automatic check_outputs();
    int idx;
    int a;
    int es;
    int ec;
    string rs;
    string rc;
    idx = (cyc + 16 - LAT) % 16;
    checks++;
    if (out_valid !== rv[idx]) fail("R5", "out_valid", int'(out_valid), int'(rv[idx]));
    if (out_valid && rv[idx]) begin
      a  = ra[idx];
      es = ref_sin(a);
      ec = ref_cos(a);
      rs = "R2";
      rc = "R3";
      if (a == 16384 || a == -16384) begin rs = "R1"; rc = "R1"; end
      if (a == -32768 || a == 32767) begin rs = "R8"; rc = "R8"; end
      if (ec == 32767 || ec == -32768) rc = "R4";
      if (a == 0) begin
        checks += 2;
        if (sin_out !== 16'sd0)     fail("R8", "sin at zero", int'(sin_out), 0);
        if (cos_out !== 16'sd32767) fail("R8", "cos at zero", int'(cos_out), 32767);
      end else begin
        cmp_tol(rs, "sin", int'(sin_out), es);
        cmp_tol(rc, "cos", int'(cos_out), ec);
      end
      last_s = sin_out;
      last_c = cos_out;
    end else if (!out_valid) begin
      checks++;
      if (sin_out !== last_s || cos_out !== last_c)
        fail("R6", "held sin", int'(sin_out), int'(last_s));
    end
  endtask

  task automatic step(input bit v, input logic signed [15:0] a);
    @(negedge clk);
    check_outputs();
    rv[cyc % 16] = v;
    ra[cyc % 16] = a;
    in_valid = v;
    in_angle = a;
    cyc++;
  endtask

  task automatic check_quiet(input string what);
    checks++;
    if (out_valid !== 1'b0 || sin_out !== 16'sd0 || cos_out !== 16'sd0)
      fail("R7", what, int'(out_valid) + int'(sin_out) + int'(cos_out), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_angle = '0;
    #1;
    check_quiet("outputs at reset entry");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_quiet("outputs during reset");
    end
    for (int i = 0; i < 16; i++) begin
      rv[i] = 1'b0;
      ra[i] = '0;
    end
    last_s = '0;
    last_c = '0;
    rst_n  = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_angle = '0;
    do_reset();

    // R1 R2 R3 R4 R5 R8: every code, back to back
    for (int a = -32768; a <= 32767; a++) step(1'b1, 16'(a));
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0);

    // R6 R5: sparse traffic with gaps of varying length
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], lfsr);
    end
    step(1'b1, 16'sd0);
    for (int i = 0; i < 12; i++) step(1'b0, 16'sd1234);
    step(1'b1, -16'sd32768);
    step(1'b1, 16'sd32767);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0);

    // R7: reset with a pipeline full of requests, nothing may emerge after
    for (int i = 0; i < 6; i++) step(1'b1, 16'(i * 5000));
    do_reset();
    for (int i = 0; i < LAT + 6; i++) step(1'b0, '0);
    for (int i = 0; i < 4; i++) step(1'b1, 16'(-i * 7000));
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule